// File: doc/BRIEF.md
# Keyed Watchdog Timer with Early-Warning Interrupt

This block is a countdown watchdog for a system that must be reset when software stops servicing it. Software stores a 32-bit timeout and a 32-bit early-warning threshold through a small word-addressed register bus. Each value is split into a low 16-bit half and a high 16-bit half. Once the count is enabled, the counter steps down by one on every slow-domain tick. When the count passes the threshold, the block raises a maskable interrupt. When the count runs out, it raises a reset request and starts again from the stored timeout. Software keeps the system alive by rewriting a load register before the count runs out.

Writes to every register except the key register are ignored until a key value has been written to the key register. Reads are always allowed. A loaded value does not reach the counter at once. A small load sequencer (states `LD_IDLE`, `LD_SYNC`, `LD_COMMIT`) holds a busy flag for a fixed number of ticks and then commits the staged values in one clock. It moves from `LD_IDLE` to `LD_SYNC` on any accepted load write. It moves from `LD_SYNC` to `LD_COMMIT` on the last tick of the wait, and from `LD_COMMIT` back to `LD_IDLE`. A new load write in `LD_SYNC` or `LD_COMMIT` restarts the wait in `LD_SYNC`.

The count has its own state machine with states `CNT_HALT`, `CNT_RUN` and `CNT_RSTREQ`:
- `CNT_HALT` to `CNT_RUN` when the enable bit is set.
- `CNT_RUN` to `CNT_HALT` when the enable bit is cleared.
- `CNT_RUN` to `CNT_RSTREQ` on an expiry while the reset enable bit is set.
- `CNT_RSTREQ` to `CNT_RUN`, or to `CNT_HALT` if the count is disabled, on the next tick.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the key register (0x20) reads 1, meaning locked. Control, mask, status, both load values and the count read 0, and `irq_o` and `rst_req_o` are low.
- R2: Writing exactly 0x0000E551 to the key register unlocks the block, and the key register then reads 0. Writing any other value locks it, and it reads 1. While the block is locked, writes to every other offset change nothing.
- R3: The timeout is stored through 0x00 (bits 15:0) and 0x04 (bits 31:16). The threshold is stored through 0x2C (bits 15:0) and 0x30 (bits 31:16). Each of these registers reads back its stored half.
- R4: An accepted write to any of the four load offsets sets status bit 4 (busy). Busy stays high through LOAD_TICKS ticks and one further clock, and then drops. At that moment the counter and the committed threshold take the stored values, and the count reads back through 0x18 (bits 15:0) and 0x1C (bits 31:16).
- R5: Control (0x08) bit 1 enables counting. While it is set, each tick lowers the count by one. Clearing it freezes the count.
- R6: When a counting tick makes the count equal the committed threshold and control bit 0 is set, status (0x10) bit 0 is set.
- R7: `irq_o` is high exactly when status bit 0 is set and mask (0x14) bit 0 is clear.
- R8: A counting tick that finds the count at zero reloads the committed timeout. If control bit 3 is set, that tick also sets status bit 3 and raises `rst_req_o`. `rst_req_o` stays high until the next tick, and that tick does not count down.
- R9: Writing 0x0C with bit 0 set clears status bit 0, and writing it with bit 3 set clears status bit 3. If a set and a clear of the same flag happen in the same cycle, the set wins.
- R10: A load write while counting acts as a keep-alive. After the busy wait, the countdown restarts from the new value, and no reset request is made.
- R11: With control bit 0 clear, reaching the threshold does not set status bit 0. With control bit 3 clear, an expiry reloads the count without setting status bit 3 or raising `rst_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-clock strobe per slow-domain count step |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | Reset request to the system reset controller |

## Verification
The bench keeps the 16-bit halves and the 32-bit bus, and sets LOAD_TICKS to 3. This covers the longer of the two busy lengths and makes the keep-alive race with an expiry a close one. Because the timeouts are kept small (2 to 7), the bench can sweep every threshold below each timeout. In each case it follows the count tick by tick through the interrupt point, the expiry, the reset pulse and the reload. A separate load puts nonzero values in the high halves to check that the two halves are assembled correctly.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Register offsets; software decodes these, so they are fixed.
    localparam int OFF_LOAD_LO  = 'h00;
    localparam int OFF_LOAD_HI  = 'h04;
    localparam int OFF_CTRL     = 'h08;
    localparam int OFF_INT_CLR  = 'h0C;
    localparam int OFF_STATUS   = 'h10;
    localparam int OFF_MASK     = 'h14;
    localparam int OFF_CNT_LO   = 'h18;
    localparam int OFF_CNT_HI   = 'h1C;
    localparam int OFF_KEY      = 'h20;
    localparam int OFF_PRE_LO   = 'h2C;
    localparam int OFF_PRE_HI   = 'h30;

    localparam logic [15:0] UNLOCK_KEY = 16'hE551;

    localparam int CTRL_W       = 4;
    localparam int ST_INT_BIT   = 0;
    localparam int ST_RST_BIT   = 3;
    localparam int ST_BUSY_BIT  = 4;
    localparam int CLR_INT_BIT  = 0;
    localparam int CLR_RST_BIT  = 3;

    typedef struct packed {
        logic rst_en;   // bit 3
        logic mode_en;  // bit 2
        logic cnt_en;   // bit 1
        logic int_en;   // bit 0
    } ctrl_t;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_SYNC,
        LD_COMMIT
    } ld_state_e;

    typedef enum logic [1:0] {
        CNT_HALT,
        CNT_RUN,
        CNT_RSTREQ
    } cnt_state_e;

endpackage

// File: rtl/wdg_regfile.sv
module wdg_regfile
    import wdg_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [2*HALF_W-1:0] count,
    input  logic                int_flag,
    input  logic                rst_flag,
    input  logic                busy,
    output logic                locked,
    output ctrl_t               ctrl,
    output logic                mask,
    output logic [2*HALF_W-1:0] tmo_val,
    output logic [2*HALF_W-1:0] pre_val,
    output logic                load_wr,
    output logic                clr_int,
    output logic                clr_rst
);

    function automatic logic hit(input int off);
        return bus_addr == ADDR_W'(off);
    endfunction

    logic wr_ok;

    always_comb begin
        wr_ok   = bus_wr && !locked;
        load_wr = wr_ok && (hit(OFF_LOAD_LO) || hit(OFF_LOAD_HI) ||
                            hit(OFF_PRE_LO)  || hit(OFF_PRE_HI));
        clr_int = wr_ok && hit(OFF_INT_CLR) && bus_wdata[CLR_INT_BIT];
        clr_rst = wr_ok && hit(OFF_INT_CLR) && bus_wdata[CLR_RST_BIT];
    end

    // Key register: accepted in any lock state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked <= 1'b1;
        end else if (bus_wr && hit(OFF_KEY)) begin
            locked <= (bus_wdata != DATA_W'(UNLOCK_KEY));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
            mask <= 1'b0;
        end else if (wr_ok) begin
            if (hit(OFF_CTRL)) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (hit(OFF_MASK)) mask <= bus_wdata[0];
        end
    end

    // Split load registers: one half per offset.
    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam int TMO_OFF = (h == 0) ? OFF_LOAD_LO : OFF_LOAD_HI;
        localparam int PRE_OFF = (h == 0) ? OFF_PRE_LO : OFF_PRE_HI;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tmo_val[h*HALF_W +: HALF_W] <= '0;
                pre_val[h*HALF_W +: HALF_W] <= '0;
            end else if (wr_ok) begin
                if (hit(TMO_OFF)) tmo_val[h*HALF_W +: HALF_W] <= bus_wdata[HALF_W-1:0];
                if (hit(PRE_OFF)) pre_val[h*HALF_W +: HALF_W] <= bus_wdata[HALF_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_LOAD_LO): bus_rdata[HALF_W-1:0] = tmo_val[HALF_W-1:0];
            ADDR_W'(OFF_LOAD_HI): bus_rdata[HALF_W-1:0] = tmo_val[2*HALF_W-1:HALF_W];
            ADDR_W'(OFF_PRE_LO):  bus_rdata[HALF_W-1:0] = pre_val[HALF_W-1:0];
            ADDR_W'(OFF_PRE_HI):  bus_rdata[HALF_W-1:0] = pre_val[2*HALF_W-1:HALF_W];
            ADDR_W'(OFF_CNT_LO):  bus_rdata[HALF_W-1:0] = count[HALF_W-1:0];
            ADDR_W'(OFF_CNT_HI):  bus_rdata[HALF_W-1:0] = count[2*HALF_W-1:HALF_W];
            ADDR_W'(OFF_CTRL):    bus_rdata[CTRL_W-1:0] = ctrl;
            ADDR_W'(OFF_MASK):    bus_rdata[0] = mask;
            ADDR_W'(OFF_KEY):     bus_rdata[0] = locked;
            ADDR_W'(OFF_STATUS): begin
                bus_rdata[ST_INT_BIT]  = int_flag;
                bus_rdata[ST_RST_BIT]  = rst_flag;
                bus_rdata[ST_BUSY_BIT] = busy;
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdg_loader.sv
module wdg_loader
    import wdg_pkg::*;
#(
    parameter int LOAD_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load_wr,
    output logic busy,
    output logic commit
);

    localparam int TW = (LOAD_TICKS > 1) ? $clog2(LOAD_TICKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(LOAD_TICKS - 1);

    ld_state_e       state, state_d;
    logic [TW-1:0]   tcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LD_IDLE;
            tcnt  <= '0;
        end else begin
            state <= state_d;
            if (load_wr)                        tcnt <= '0;
            else if (state == LD_SYNC && tick)  tcnt <= tcnt + TW'(1);
        end
    end

    always_comb begin
        state_d = state;
        unique case (state)
            LD_IDLE:   if (load_wr) state_d = LD_SYNC;
            LD_SYNC:   if (!load_wr && tick && tcnt == LAST) state_d = LD_COMMIT;
            LD_COMMIT: state_d = load_wr ? LD_SYNC : LD_IDLE;
            default:   state_d = LD_IDLE;
        endcase
    end

    always_comb begin
        busy   = (state != LD_IDLE);
        commit = (state == LD_COMMIT) && !load_wr;
    end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             commit,
    input  logic             cnt_en,
    input  logic             int_en,
    input  logic             rst_en,
    input  logic [CNT_W-1:0] tmo_val,
    input  logic [CNT_W-1:0] pre_val,
    input  logic             clr_int,
    input  logic             clr_rst,
    output logic [CNT_W-1:0] count,
    output logic             int_flag,
    output logic             rst_flag,
    output logic             rst_req,
    output cnt_state_e       state
);

    cnt_state_e       state_d;
    logic [CNT_W-1:0] tmo_act, pre_act;
    logic             step, expire, pre_hit;

    always_comb begin
        step    = tick && !commit && (state == CNT_RUN) && cnt_en;
        expire  = step && (count == '0);
        pre_hit = step && (count != '0) && ((count - CNT_W'(1)) == pre_act);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CNT_HALT;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            CNT_HALT:   if (cnt_en) state_d = CNT_RUN;
            CNT_RUN: begin
                if (expire && rst_en) state_d = CNT_RSTREQ;
                else if (!cnt_en)     state_d = CNT_HALT;
            end
            CNT_RSTREQ: if (tick) state_d = cnt_en ? CNT_RUN : CNT_HALT;
            default:    state_d = CNT_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            tmo_act <= '0;
            pre_act <= '0;
        end else if (commit) begin
            count   <= tmo_val;
            tmo_act <= tmo_val;
            pre_act <= pre_val;
        end else if (expire) begin
            count   <= tmo_act;
        end else if (step) begin
            count   <= count - CNT_W'(1);
        end
    end

    // Flags: a set in the same cycle as a clear wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_flag <= 1'b0;
            rst_flag <= 1'b0;
        end else begin
            if (pre_hit && int_en)     int_flag <= 1'b1;
            else if (clr_int)          int_flag <= 1'b0;
            if (expire && rst_en)      rst_flag <= 1'b1;
            else if (clr_rst)          rst_flag <= 1'b0;
        end
    end

    always_comb begin
        rst_req = (state == CNT_RSTREQ);
    end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int HALF_W     = 16,
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 32,
    parameter int LOAD_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              rst_req_o
);

    localparam int CNT_W = 2 * HALF_W;

    logic             locked, mask, load_wr, clr_int, clr_rst;
    logic             busy, commit, int_flag, rst_flag;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] tmo_val, pre_val, count;
    cnt_state_e       cstate;

    wdg_regfile #(
        .HALF_W (HALF_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (count),
        .int_flag  (int_flag),
        .rst_flag  (rst_flag),
        .busy      (busy),
        .locked    (locked),
        .ctrl      (ctrl_q),
        .mask      (mask),
        .tmo_val   (tmo_val),
        .pre_val   (pre_val),
        .load_wr   (load_wr),
        .clr_int   (clr_int),
        .clr_rst   (clr_rst)
    );

    wdg_loader #(
        .LOAD_TICKS (LOAD_TICKS)
    ) u_load (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load_wr (load_wr),
        .busy    (busy),
        .commit  (commit)
    );

    wdg_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .commit   (commit),
        .cnt_en   (ctrl_q.cnt_en),
        .int_en   (ctrl_q.int_en),
        .rst_en   (ctrl_q.rst_en),
        .tmo_val  (tmo_val),
        .pre_val  (pre_val),
        .clr_int  (clr_int),
        .clr_rst  (clr_rst),
        .count    (count),
        .int_flag (int_flag),
        .rst_flag (rst_flag),
        .rst_req  (rst_req_o),
        .state    (cstate)
    );

    always_comb begin
        irq_o = int_flag && !mask;
    end

endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk
    import wdg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             locked,
    input ctrl_t            ctrl,
    input logic             load_wr,
    input logic             busy,
    input logic             commit,
    input logic [CNT_W-1:0] count,
    input cnt_state_e       cstate,
    input logic             int_flag,
    input logic             rst_flag,
    input logic             rst_req_o
);

    assert_locked_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(ctrl));

    assert_busy_after_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> busy);

    assert_halt_freezes_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate == CNT_HALT && !commit) |=> $stable(count));

    assert_int_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_flag) |-> $past(ctrl.int_en));

    assert_rstreq_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> rst_flag);

    assert_rstreq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_o && !tick) |=> rst_req_o);

endmodule

bind keyed_watchdog keyed_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .locked    (locked),
    .ctrl      (ctrl_q),
    .load_wr   (load_wr),
    .busy      (busy),
    .commit    (commit),
    .count     (count),
    .cstate    (cstate),
    .int_flag  (int_flag),
    .rst_flag  (rst_flag),
    .rst_req_o (rst_req_o)
);

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;

    localparam int LT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, rst_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    keyed_watchdog #(
        .HALF_W (16), .ADDR_W (6), .DATA_W (32), .LOAD_TICKS (LT)
    ) uut (
        .clk (clk), .rst_n (rst_n), .tick (tick), .bus_wr (bus_wr),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .irq_o (irq_o), .rst_req_o (rst_req_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_tick(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_rd(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic tick1();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic finish_load();
        repeat (LT) tick1();
        settle();
    endtask

    task automatic run_case(input int t, input int p);
        logic [31:0] st;
        wr(6'h08, 0); settle();
        wr(6'h0C, 32'h9);
        wr(6'h2C, p); wr(6'h30, 0); wr(6'h04, 0); wr(6'h00, t);
        finish_load();
        chk_rd("R4 commit sets count", 6'h18, t);
        wr(6'h08, 32'hB); settle();
        for (int k = 1; k <= t + 1; k++) begin
            tick1();
            rd(6'h10, st);
            if (k <= t) begin
                chk_rd("R5 count step", 6'h18, t - k);
                chk("R6 threshold flag", st[0], (k >= t - p) ? 1 : 0);
                chk("R7 irq follows flag", irq_o, (k >= t - p) ? 1 : 0);
                chk("R8 no early reset", rst_req_o, 0);
            end else begin
                chk_rd("R8 reload on expiry", 6'h18, t);
                chk("R8 reset request", rst_req_o, 1);
                chk("R8 reset flag", st[3], 1);
            end
        end
        tick1();
        chk("R8 pulse ends next tick", rst_req_o, 0);
        chk_rd("R8 no step on pulse-ending tick", 6'h18, t);
        tick1();
        chk_rd("R8 counting resumes", 6'h18, t - 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1 reset state
        chk_rd("R1 key reads locked", 6'h20, 1);
        chk_rd("R1 ctrl", 6'h08, 0);
        chk_rd("R1 mask", 6'h14, 0);
        chk_rd("R1 status", 6'h10, 0);
        chk_rd("R1 count lo", 6'h18, 0);
        chk_rd("R1 count hi", 6'h1C, 0);
        chk_rd("R1 load lo", 6'h00, 0);
        chk_rd("R1 pre hi", 6'h30, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 rst_req", rst_req_o, 0);

        // R2 writes ignored while locked
        wr(6'h08, 32'hF);
        chk_rd("R2 locked ctrl ignored", 6'h08, 0);
        wr(6'h00, 5);
        chk_rd("R2 locked load ignored, no busy", 6'h10, 0);
        chk_rd("R2 locked load value", 6'h00, 0);
        wr(6'h20, 32'h0000E551);
        chk_rd("R2 key unlocks", 6'h20, 0);

        // R3 / R4 split loads and busy window
        wr(6'h04, 32'h0001); wr(6'h00, 32'h0002);
        wr(6'h30, 32'hABCD); wr(6'h2C, 32'h1234);
        chk_rd("R3 load lo", 6'h00, 32'h0002);
        chk_rd("R3 load hi", 6'h04, 32'h0001);
        chk_rd("R3 pre lo", 6'h2C, 32'h1234);
        chk_rd("R3 pre hi", 6'h30, 32'hABCD);
        chk_rd("R4 busy after load", 6'h10, 32'h10);
        repeat (LT) tick1();
        chk_rd("R4 busy through ticks", 6'h10, 32'h10);
        chk_rd("R4 count not yet committed", 6'h18, 0);
        settle();
        chk_rd("R4 busy dropped", 6'h10, 0);
        chk_rd("R4 count lo", 6'h18, 32'h0002);
        chk_rd("R4 count hi", 6'h1C, 32'h0001);

        // Sweep: every threshold below each small timeout
        for (int t = 2; t <= 7; t++)
            for (int p = 0; p < t; p++)
                run_case(t, p);

        // R9 selective clears
        wr(6'h0C, 32'h8);
        chk_rd("R9 clear reset flag only", 6'h10, 32'h1);
        wr(6'h0C, 32'h1);
        chk_rd("R9 clear int flag", 6'h10, 0);

        // R5 freeze, R11 disabled interrupt and reset
        wr(6'h08, 0); settle();
        wr(6'h0C, 32'h9);
        wr(6'h2C, 5); wr(6'h00, 10);
        finish_load();
        wr(6'h08, 32'h2); settle();
        repeat (6) tick1();
        chk_rd("R5 count after six", 6'h18, 4);
        chk_rd("R11 no flag without int enable", 6'h10, 0);
        wr(6'h08, 0); settle();
        repeat (3) tick1();
        chk_rd("R5 frozen", 6'h18, 4);
        wr(6'h08, 32'h2); settle();
        repeat (5) tick1();
        chk_rd("R11 silent reload", 6'h18, 10);
        chk("R11 no reset request", rst_req_o, 0);
        chk_rd("R11 no reset flag", 6'h10, 0);

        // R7 mask, R9 clear
        wr(6'h08, 0); settle();
        wr(6'h14, 1);
        wr(6'h2C, 2); wr(6'h00, 4);
        finish_load();
        wr(6'h08, 32'h3); settle();
        tick1(); tick1();
        chk_rd("R7 flag set while masked", 6'h10, 1);
        chk("R7 masked irq", irq_o, 0);
        wr(6'h14, 0);
        chk("R7 unmasked irq", irq_o, 1);
        wr(6'h0C, 32'h1);
        chk_rd("R9 int cleared", 6'h10, 0);
        chk("R9 irq drops", irq_o, 0);

        // R9 set wins over a same-cycle clear
        wr(6'h08, 0); settle();
        wr(6'h00, 3);
        finish_load();
        wr(6'h08, 32'h3); settle();
        wr_tick(6'h0C, 32'h1);
        chk_rd("R9 count at threshold", 6'h18, 2);
        chk_rd("R9 set wins", 6'h10, 1);
        wr(6'h0C, 32'h1);

        // R10 keep-alive
        wr(6'h08, 0); settle();
        wr(6'h0C, 32'h9);
        wr(6'h2C, 0); wr(6'h00, 8);
        finish_load();
        wr(6'h08, 32'hA); settle();
        repeat (8 - LT - 1) tick1();
        chk_rd("R10 before refresh", 6'h18, 1 + LT);
        wr(6'h00, 8);
        finish_load();
        chk_rd("R10 restarted", 6'h18, 8);
        chk("R10 no reset request", rst_req_o, 0);
        chk_rd("R10 no reset flag", 6'h10, 0);
        tick1(); tick1();
        chk_rd("R10 counting from new value", 6'h18, 6);

        // R2 non-key value locks
        wr(6'h20, 32'h1234);
        chk_rd("R2 other value locks", 6'h20, 1);
        wr(6'h08, 0);
        chk_rd("R2 ctrl held while locked", 6'h08, 32'hA);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule